// File: doc/BRIEF.md
# Cache maintenance command engine

This block runs maintenance commands against two small lookup caches that sit next to a hash search engine. One cache holds flow-table results and the other holds address-table results. A command names an operation, picks a cache and a status channel, and carries a 64-bit metadata word. The engine works on one command at a time. A command can touch a single line, located either by tag search or directly by index. It can also sweep every line of the chosen cache. Each command ends with one status record on the chosen channel.

Every line holds a valid flag, a dirty flag, a 20-bit tag, a data word and a statistics counter. Lines are installed through a fill port that stands for the search engine's result path. A write-back is a one-cycle pulse on the write-back port that carries the line's tag and data. The external memory, the hash search and descriptor fetch are left out.

If a fill and a command update hit the same line in the same cycle, the command update wins for the flags and the statistics.

Top module: `cmaint_engine`

## Requirements
- R1: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` goes low in the next cycle and comes back high in the cycle the status record appears. A single-line command's status appears two clock edges after acceptance. After reset, `cmd_ready` is high and no status or write-back is pending.
- R2: The 64-bit metadata is returned unchanged. Exactly one bit of `st_valid` pulses per command: bit 0 when `cmd_dst` is 0, and bit 1 when `cmd_dst` is 1.
- R3: Opcode 0 (read statistics) reports the hit line's counter and leaves the line unchanged.
- R4: Opcode 1 (hash only) does no lookup. Its status carries `key[15:0] XOR key[19:16]` in `st_stat`, with `st_miss` at 0.
- R5: Opcode 2 (write back one line) emits one write-back pulse with the line's tag and data when the hit line is dirty. It then marks the line clean, so a repeat of the command emits nothing. The status reports the line's counter.
- R6: Opcode 4 invalidates the hit line without any write-back. Opcode 6 writes the hit line back if it is dirty and then invalidates it. Both report the line's counter, and a later lookup of that line misses.
- R7: Opcode 8 reports the counter as it was and then sets it to zero.
- R8: Opcodes 3 (write back all), 5 (invalidate all) and 7 (write back and invalidate all) step through the lines, one per clock, from line 0 upward. `cmd_ready` stays low for exactly LINES cycles. A write-back is emitted only for lines that are both valid and dirty, in ascending line order. The status carries zero statistics.
- R9: Opcodes 9 to 15 set `st_err` in the status record. They change no line and emit no write-back.
- R10: A single-line command with no valid matching line sets `st_miss`, reports zero statistics and emits no write-back.
- R11: `cmd_sel` = 0 targets the flow cache and 1 targets the address cache. A command never alters the other cache.
- R12: When `cmd_idx` is 1, the line is `cmd_set` (modulo LINES), and it hits only if that line is valid and its tag equals `cmd_key`. When `cmd_idx` is 0, all lines are searched and the lowest-numbered valid line with a matching tag is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 4 | Operation code |
| cmd_sel | input | 1 | Target cache: 0 flow, 1 address |
| cmd_dst | input | 1 | Status channel select |
| cmd_idx | input | 1 | Index-mode addressing |
| cmd_set | input | SET_W | Line number used in index mode |
| cmd_key | input | TAG_W | Tag or index taken from the low address bits |
| cmd_meta | input | META_W | Opaque metadata echoed in the status |
| fill_en | input | 1 | Install a line |
| fill_sel | input | 1 | Cache receiving the fill |
| fill_line | input | log2(LINES) | Line being filled |
| fill_tag | input | TAG_W | Tag of the filled line |
| fill_data | input | DATA_W | Data of the filled line |
| fill_dirty | input | 1 | Dirty flag of the filled line |
| fill_stat | input | STAT_W | Initial statistics counter |
| wb_valid | output | 1 | Write-back pulse |
| wb_sel | output | 1 | Cache that produced the write-back |
| wb_tag | output | TAG_W | Tag of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |
| st_valid | output | 2 | Status pulse, one bit per channel |
| st_meta | output | META_W | Echoed metadata |
| st_stat | output | STAT_W | Reported statistics or hash |
| st_miss | output | 1 | Single-line lookup missed |
| st_err | output | 1 | Reserved opcode |

## Verification
The caches are filled with a mix of lines. Some are dirty and some clean. One tag appears on two lines, and one line is invalid but still carries a dirty flag. Running the same operation by tag search and by index separates the lowest-match rule from direct line selection. Repeating a write-back on the same line shows that the dirty flag was really cleared. A sweep over a mix of clean, dirty and invalid lines tells "valid and dirty" apart from "dirty" alone, and the order of the write-backs checks the ascending walk. Reserved opcodes and misses are aimed at dirty lines, so any write-back they leak is caught. Sending commands to one cache and then reading the other confirms that the two caches stay separate.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  localparam logic [3:0] OP_STAT_RD  = 4'd0;
  localparam logic [3:0] OP_HASH     = 4'd1;
  localparam logic [3:0] OP_WB_ONE   = 4'd2;
  localparam logic [3:0] OP_WB_ALL   = 4'd3;
  localparam logic [3:0] OP_INV_ONE  = 4'd4;
  localparam logic [3:0] OP_INV_ALL  = 4'd5;
  localparam logic [3:0] OP_WBI_ONE  = 4'd6;
  localparam logic [3:0] OP_WBI_ALL  = 4'd7;
  localparam logic [3:0] OP_STAT_CLR = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WALK = 2'd2
  } cm_state_e;

  function automatic logic op_sweeps(input logic [3:0] op);
    return (op == OP_WB_ALL) || (op == OP_INV_ALL) || (op == OP_WBI_ALL);
  endfunction

  function automatic logic op_writes_back(input logic [3:0] op);
    return (op == OP_WB_ONE) || (op == OP_WB_ALL) ||
           (op == OP_WBI_ONE) || (op == OP_WBI_ALL);
  endfunction

  function automatic logic op_invalidates(input logic [3:0] op);
    return (op == OP_INV_ONE) || (op == OP_INV_ALL) ||
           (op == OP_WBI_ONE) || (op == OP_WBI_ALL);
  endfunction

  function automatic logic op_reserved(input logic [3:0] op);
    return op > OP_STAT_CLR;
  endfunction

endpackage

// File: rtl/cmaint_bank.sv
module cmaint_bank #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int SET_W  = 4,
  localparam int LW    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [LW-1:0]     fill_line,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_dirty,
  input  logic [STAT_W-1:0] fill_stat,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              look_idx,
  input  logic [SET_W-1:0]  look_set,
  output logic              look_hit,
  output logic [LW-1:0]     look_line,
  input  logic [LW-1:0]     rd_line,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  input  logic              upd_en,
  input  logic              upd_clr_valid,
  input  logic              upd_clr_dirty,
  input  logic              upd_clr_stat
);

  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  dty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [STAT_W-1:0] stat_q [LINES];
  logic [LINES-1:0]  match;
  logic [LW-1:0]     idx_line;

  // per-line tag comparators for the associative search
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == look_tag);
  end

  assign idx_line = LW'(look_set);

  always_comb begin
    look_hit  = 1'b0;
    look_line = '0;
    if (look_idx) begin
      look_line = idx_line;
      look_hit  = match[idx_line];
    end else begin
      // scan downward so that the lowest matching line wins
      for (int i = LINES - 1; i >= 0; i--) begin
        if (match[i]) begin
          look_hit  = 1'b1;
          look_line = LW'(i);
        end
      end
    end
  end

  assign rd_valid = vld_q[rd_line];
  assign rd_dirty = dty_q[rd_line];
  assign rd_tag   = tag_q[rd_line];
  assign rd_data  = data_q[rd_line];
  assign rd_stat  = stat_q[rd_line];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dty_q <= '0;
    end else begin
      if (fill_en) begin
        vld_q[fill_line] <= 1'b1;
        dty_q[fill_line] <= fill_dirty;
      end
      if (upd_en) begin
        if (upd_clr_valid) vld_q[rd_line] <= 1'b0;
        if (upd_clr_dirty) dty_q[rd_line] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_line]  <= fill_tag;
      stat_q[fill_line] <= fill_stat;
    end
    if (upd_en && upd_clr_stat) stat_q[rd_line] <= '0;
  end

  // data store: single write port, no reset
  always_ff @(posedge clk) begin
    if (fill_en) data_q[fill_line] <= fill_data;
  end

endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
  import cmaint_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int META_W = 64,
  parameter int SET_W  = 4,
  localparam int LW    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic              cmd_sel,
  input  logic              cmd_dst,
  input  logic              cmd_idx,
  input  logic [SET_W-1:0]  cmd_set,
  input  logic [TAG_W-1:0]  cmd_key,
  input  logic [META_W-1:0] cmd_meta,
  output logic              q_sel,
  output logic [TAG_W-1:0]  q_tag,
  output logic              q_idx,
  output logic [SET_W-1:0]  q_set,
  input  logic              look_hit,
  input  logic [LW-1:0]     look_line,
  output logic [LW-1:0]     rd_line,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [STAT_W-1:0] rd_stat,
  output logic              upd_en,
  output logic              upd_clr_valid,
  output logic              upd_clr_dirty,
  output logic              upd_clr_stat,
  output logic              wb_valid,
  output logic              wb_sel,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data,
  output logic [1:0]        st_valid,
  output logic [META_W-1:0] st_meta,
  output logic [STAT_W-1:0] st_stat,
  output logic              st_miss,
  output logic              st_err
);

  cm_state_e         state_q;
  logic [LW-1:0]     ptr_q;
  logic [3:0]        op_q;
  logic              dst_q;
  logic [META_W-1:0] meta_q;

  logic              walking, executing, rsvd, single, line_ok, do_wb;
  logic              last_line, finishing;
  logic [STAT_W-1:0] hash_v, stat_v;

  assign cmd_ready = (state_q == ST_IDLE);

  always_comb begin
    walking   = (state_q == ST_WALK);
    executing = (state_q == ST_EXEC);
    rsvd      = op_reserved(op_q);
    single    = executing && !rsvd && (op_q != OP_HASH);
    rd_line   = walking ? ptr_q : look_line;
    line_ok   = walking ? rd_valid : look_hit;
    do_wb     = (walking || single) && line_ok && rd_dirty && op_writes_back(op_q);

    upd_en        = (walking || single) && line_ok;
    upd_clr_valid = op_invalidates(op_q);
    upd_clr_dirty = op_writes_back(op_q);
    upd_clr_stat  = single && (op_q == OP_STAT_CLR);

    last_line = (ptr_q == LW'(LINES - 1));
    finishing = executing || (walking && last_line);

    hash_v = STAT_W'(q_tag) ^ STAT_W'(q_tag >> STAT_W);
    if (executing && (op_q == OP_HASH)) stat_v = hash_v;
    else if (single && look_hit)        stat_v = rd_stat;
    else                                stat_v = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      wb_valid <= 1'b0;
      st_valid <= 2'b00;
    end else begin
      wb_valid <= do_wb;
      st_valid <= finishing ? (dst_q ? 2'b10 : 2'b01) : 2'b00;
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          state_q <= op_sweeps(cmd_op) ? ST_WALK : ST_EXEC;
          ptr_q   <= '0;
        end
        ST_EXEC: state_q <= ST_IDLE;
        ST_WALK: begin
          ptr_q <= ptr_q + 1'b1;
          if (last_line) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // command and result payload registers, no reset needed
  always_ff @(posedge clk) begin
    if (cmd_valid && cmd_ready) begin
      op_q   <= cmd_op;
      q_sel  <= cmd_sel;
      dst_q  <= cmd_dst;
      q_idx  <= cmd_idx;
      q_set  <= cmd_set;
      q_tag  <= cmd_key;
      meta_q <= cmd_meta;
    end
    if (do_wb) begin
      wb_sel  <= q_sel;
      wb_tag  <= rd_tag;
      wb_data <= rd_data;
    end
    if (finishing) begin
      st_meta <= meta_q;
      st_stat <= stat_v;
      st_miss <= single && !look_hit;
      st_err  <= executing && rsvd;
    end
  end

endmodule

// File: rtl/cmaint_engine.sv
module cmaint_engine #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int META_W = 64,
  parameter int SET_W  = 4,
  localparam int LW    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic              cmd_sel,
  input  logic              cmd_dst,
  input  logic              cmd_idx,
  input  logic [SET_W-1:0]  cmd_set,
  input  logic [TAG_W-1:0]  cmd_key,
  input  logic [META_W-1:0] cmd_meta,
  input  logic              fill_en,
  input  logic              fill_sel,
  input  logic [LW-1:0]     fill_line,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_dirty,
  input  logic [STAT_W-1:0] fill_stat,
  output logic              wb_valid,
  output logic              wb_sel,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data,
  output logic [1:0]        st_valid,
  output logic [META_W-1:0] st_meta,
  output logic [STAT_W-1:0] st_stat,
  output logic              st_miss,
  output logic              st_err
);

  localparam int NBANK = 2;

  logic              q_sel, q_idx;
  logic [TAG_W-1:0]  q_tag;
  logic [SET_W-1:0]  q_set;
  logic [LW-1:0]     rd_line;
  logic              upd_en, upd_clr_valid, upd_clr_dirty, upd_clr_stat;

  logic              bk_hit   [NBANK];
  logic [LW-1:0]     bk_line  [NBANK];
  logic              bk_valid [NBANK];
  logic              bk_dirty [NBANK];
  logic [TAG_W-1:0]  bk_tag   [NBANK];
  logic [DATA_W-1:0] bk_data  [NBANK];
  logic [STAT_W-1:0] bk_stat  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cmaint_bank #(
      .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W),
      .STAT_W(STAT_W), .SET_W(SET_W)
    ) u_bank (
      .clk           (clk),
      .rst           (rst),
      .fill_en       (fill_en && (fill_sel == 1'(b))),
      .fill_line     (fill_line),
      .fill_tag      (fill_tag),
      .fill_data     (fill_data),
      .fill_dirty    (fill_dirty),
      .fill_stat     (fill_stat),
      .look_tag      (q_tag),
      .look_idx      (q_idx),
      .look_set      (q_set),
      .look_hit      (bk_hit[b]),
      .look_line     (bk_line[b]),
      .rd_line       (rd_line),
      .rd_valid      (bk_valid[b]),
      .rd_dirty      (bk_dirty[b]),
      .rd_tag        (bk_tag[b]),
      .rd_data       (bk_data[b]),
      .rd_stat       (bk_stat[b]),
      .upd_en        (upd_en && (q_sel == 1'(b))),
      .upd_clr_valid (upd_clr_valid),
      .upd_clr_dirty (upd_clr_dirty),
      .upd_clr_stat  (upd_clr_stat)
    );
  end

  cmaint_seq #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .STAT_W(STAT_W), .META_W(META_W), .SET_W(SET_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_sel       (cmd_sel),
    .cmd_dst       (cmd_dst),
    .cmd_idx       (cmd_idx),
    .cmd_set       (cmd_set),
    .cmd_key       (cmd_key),
    .cmd_meta      (cmd_meta),
    .q_sel         (q_sel),
    .q_tag         (q_tag),
    .q_idx         (q_idx),
    .q_set         (q_set),
    .look_hit      (bk_hit[q_sel]),
    .look_line     (bk_line[q_sel]),
    .rd_line       (rd_line),
    .rd_valid      (bk_valid[q_sel]),
    .rd_dirty      (bk_dirty[q_sel]),
    .rd_tag        (bk_tag[q_sel]),
    .rd_data       (bk_data[q_sel]),
    .rd_stat       (bk_stat[q_sel]),
    .upd_en        (upd_en),
    .upd_clr_valid (upd_clr_valid),
    .upd_clr_dirty (upd_clr_dirty),
    .upd_clr_stat  (upd_clr_stat),
    .wb_valid      (wb_valid),
    .wb_sel        (wb_sel),
    .wb_tag        (wb_tag),
    .wb_data       (wb_data),
    .st_valid      (st_valid),
    .st_meta       (st_meta),
    .st_stat       (st_stat),
    .st_miss       (st_miss),
    .st_err        (st_err)
  );

endmodule

// File: rtl/cmaint_engine_chk.sv
module cmaint_engine_chk #(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              wb_valid,
  input logic [1:0]        st_valid,
  input logic [STAT_W-1:0] st_stat,
  input logic              st_miss,
  input logic              st_err
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready); // R1

  AST_STATUS_FREES: assert property (@(posedge clk) disable iff (rst)
    (|st_valid) |-> cmd_ready); // R1

  AST_NO_STATUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_ready && $past(cmd_ready) && !$past(cmd_valid) |-> !(|st_valid)); // R1

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_valid)); // R2

  AST_MISS_NO_STAT: assert property (@(posedge clk) disable iff (rst)
    (|st_valid) && st_miss |-> (st_stat == '0) && !st_err); // R10

  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (|st_valid) && st_err |-> (st_stat == '0) && !st_miss); // R9

  AST_WB_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(!cmd_ready)); // R8

endmodule

bind cmaint_engine cmaint_engine_chk #(.STAT_W(STAT_W)) u_chk (.*);

// File: tb/cmaint_engine_tb.sv
module cmaint_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;

  typedef struct packed {
    logic        dst;
    logic [63:0] meta;
    logic [15:0] stat;
    logic        miss;
    logic        err;
  } st_exp_t;

  typedef struct packed {
    logic        sel;
    logic [19:0] tag;
    logic [31:0] data;
  } wb_exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_ready, cmd_sel, cmd_dst, cmd_idx;
  logic [3:0]  cmd_op, cmd_set;
  logic [19:0] cmd_key;
  logic [63:0] cmd_meta;
  logic        fill_en, fill_sel, fill_dirty;
  logic [3:0]  fill_line;
  logic [19:0] fill_tag;
  logic [31:0] fill_data;
  logic [15:0] fill_stat;
  logic        wb_valid, wb_sel;
  logic [19:0] wb_tag;
  logic [31:0] wb_data;
  logic [1:0]  st_valid;
  logic [63:0] st_meta;
  logic [15:0] st_stat;
  logic        st_miss, st_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  st_exp_t st_q[$];
  string   st_r[$];
  wb_exp_t wb_q[$];
  string   wb_r[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmaint_engine u_dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_dst(cmd_dst), .cmd_idx(cmd_idx),
    .cmd_set(cmd_set), .cmd_key(cmd_key), .cmd_meta(cmd_meta),
    .fill_en(fill_en), .fill_sel(fill_sel), .fill_line(fill_line),
    .fill_tag(fill_tag), .fill_data(fill_data), .fill_dirty(fill_dirty),
    .fill_stat(fill_stat),
    .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_tag(wb_tag), .wb_data(wb_data),
    .st_valid(st_valid), .st_meta(st_meta), .st_stat(st_stat),
    .st_miss(st_miss), .st_err(st_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // scoreboard monitor: compares outputs at the falling edge
  st_exp_t se;
  wb_exp_t we;
  string   sr;
  always @(negedge clk) begin
    if (!rst) begin
      if (st_valid != 2'b00) begin
        if (st_q.size() == 0) chk("R2 unexpected status", 64'd1, 64'd0);
        else begin
          se = st_q.pop_front();
          sr = st_r.pop_front();
          chk({sr, " channel"}, 64'(st_valid), se.dst ? 64'd2 : 64'd1);
          chk({sr, " meta"},    st_meta, se.meta);
          chk({sr, " stat"},    64'(st_stat), 64'(se.stat));
          chk({sr, " miss"},    64'(st_miss), 64'(se.miss));
          chk({sr, " err"},     64'(st_err), 64'(se.err));
        end
      end
      if (wb_valid) begin
        if (wb_q.size() == 0)
          chk("R10 unexpected write-back", {43'd0, wb_sel, wb_tag}, 64'd0);
        else begin
          we = wb_q.pop_front();
          sr = wb_r.pop_front();
          chk({sr, " wb"}, {11'd0, wb_sel, wb_tag, wb_data}, {11'd0, we.sel, we.tag, we.data});
        end
      end
    end
  end

  task automatic exp_st(input logic dst, input logic [63:0] meta, input logic [15:0] stat,
                        input logic miss, input logic err, input string req);
    st_q.push_back('{dst: dst, meta: meta, stat: stat, miss: miss, err: err});
    st_r.push_back(req);
  endtask

  task automatic exp_wb(input logic sel, input logic [19:0] tag, input logic [31:0] data,
                        input string req);
    wb_q.push_back('{sel: sel, tag: tag, data: data});
    wb_r.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input logic sel, input logic [3:0] line, input logic [19:0] tag,
                      input logic [31:0] data, input logic dirty, input logic [15:0] stat);
    @(negedge clk);
    fill_en = 1'b1; fill_sel = sel; fill_line = line; fill_tag = tag;
    fill_data = data; fill_dirty = dirty; fill_stat = stat;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // returns at the falling edge right after the accepting edge
  task automatic do_cmd(input logic [3:0] op, input logic sel, input logic dst,
                        input logic idx, input logic [3:0] set, input logic [19:0] key,
                        input logic [63:0] meta);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_dst = dst;
    cmd_idx = idx; cmd_set = set; cmd_key = key; cmd_meta = meta;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  localparam logic [31:0] DA = 32'hA0A0_0001, DB = 32'hB0B0_0002, DC = 32'hC0C0_0003;
  localparam logic [31:0] DD = 32'hD0D0_0004, DE = 32'hE0E0_0005, DF = 32'hF0F0_0006;
  localparam logic [31:0] DG = 32'h1111_0007, DH = 32'h2222_0008, DI = 32'h3333_0009;

  initial begin
    rst = 1'b1;
    cmd_valid = 1'b0; cmd_op = '0; cmd_sel = 1'b0; cmd_dst = 1'b0; cmd_idx = 1'b0;
    cmd_set = '0; cmd_key = '0; cmd_meta = '0;
    fill_en = 1'b0; fill_sel = 1'b0; fill_line = '0; fill_tag = '0;
    fill_data = '0; fill_dirty = 1'b0; fill_stat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset ready", 64'(cmd_ready), 64'd1);
    chk("R1 reset status", 64'(st_valid), 64'd0);
    chk("R1 reset wb", 64'(wb_valid), 64'd0);

    fill(1'b0, 4'd0, 20'h00011, DA, 1'b1, 16'd5);
    fill(1'b0, 4'd1, 20'h00022, DB, 1'b0, 16'd7);
    fill(1'b0, 4'd2, 20'h00033, DC, 1'b1, 16'd9);
    fill(1'b0, 4'd5, 20'h00011, DD, 1'b1, 16'd3);
    fill(1'b1, 4'd3, 20'h00011, DE, 1'b1, 16'd40);

    // R3 R12 tag search picks lowest line; R1 timing
    exp_st(1'b0, 64'h1000_0000_0000_0001, 16'd5, 1'b0, 1'b0, "R3 R12 search read");
    do_cmd(4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00011, 64'h1000_0000_0000_0001);
    chk("R1 busy after accept", 64'(cmd_ready), 64'd0);
    chk("R1 no early status", 64'(st_valid), 64'd0);
    @(negedge clk);
    chk("R1 status at second edge", 64'(st_valid), 64'd1);
    chk("R1 ready with status", 64'(cmd_ready), 64'd1);
    idle();

    // R12 R2 index mode to line 5, channel 1
    exp_st(1'b1, 64'h2000_0000_0000_0002, 16'd3, 1'b0, 1'b0, "R12 R2 index read");
    do_cmd(4'd0, 1'b0, 1'b1, 1'b1, 4'd5, 20'h00011, 64'h2000_0000_0000_0002);
    // R12 R10 index to line 1 with wrong tag misses
    exp_st(1'b0, 64'h3, 16'd0, 1'b1, 1'b0, "R12 R10 index miss");
    do_cmd(4'd0, 1'b0, 1'b0, 1'b1, 4'd1, 20'h00011, 64'h3);
    // R11 address cache
    exp_st(1'b0, 64'h4, 16'd40, 1'b0, 1'b0, "R11 address cache read");
    do_cmd(4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 20'h00011, 64'h4);
    // R4 hash only
    exp_st(1'b1, 64'h5, 16'hBCD4, 1'b0, 1'b0, "R4 hash");
    do_cmd(4'd1, 1'b0, 1'b1, 1'b0, 4'd0, 20'hABCDE, 64'h5);
    // R5 write back one, then repeat
    exp_wb(1'b0, 20'h00033, DC, "R5 single write-back");
    exp_st(1'b0, 64'h6, 16'd9, 1'b0, 1'b0, "R5 write-back status");
    do_cmd(4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00033, 64'h6);
    exp_st(1'b0, 64'h7, 16'd9, 1'b0, 1'b0, "R5 clean repeat");
    do_cmd(4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00033, 64'h7);
    // R7 clear statistics
    exp_st(1'b0, 64'h8, 16'd7, 1'b0, 1'b0, "R7 clear reports old");
    do_cmd(4'd8, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00022, 64'h8);
    exp_st(1'b0, 64'h9, 16'd0, 1'b0, 1'b0, "R7 counter zeroed");
    do_cmd(4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00022, 64'h9);
    // R9 reserved opcodes aimed at a dirty line
    exp_st(1'b0, 64'hA, 16'd0, 1'b0, 1'b1, "R9 opcode 15");
    do_cmd(4'd15, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00011, 64'hA);
    exp_st(1'b1, 64'hB, 16'd0, 1'b0, 1'b1, "R9 opcode 9");
    do_cmd(4'd9, 1'b0, 1'b1, 1'b0, 4'd0, 20'h00011, 64'hB);
    exp_st(1'b0, 64'hC, 16'd5, 1'b0, 1'b0, "R9 line unchanged");
    do_cmd(4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00011, 64'hC);
    // R6 write back and invalidate on address cache
    exp_wb(1'b1, 20'h00011, DE, "R6 R11 wbinv write-back");
    exp_st(1'b0, 64'hD, 16'd40, 1'b0, 1'b0, "R6 wbinv status");
    do_cmd(4'd6, 1'b1, 1'b0, 1'b0, 4'd0, 20'h00011, 64'hD);
    exp_st(1'b0, 64'hE, 16'd0, 1'b1, 1'b0, "R6 gone after wbinv");
    do_cmd(4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 20'h00011, 64'hE);
    exp_st(1'b0, 64'hF, 16'd5, 1'b0, 1'b0, "R11 flow cache untouched");
    do_cmd(4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00011, 64'hF);
    // R6 invalidate dirty line 5: no write-back
    exp_st(1'b0, 64'h10, 16'd3, 1'b0, 1'b0, "R6 invalidate status");
    do_cmd(4'd4, 1'b0, 1'b0, 1'b1, 4'd5, 20'h00011, 64'h10);
    exp_st(1'b0, 64'h11, 16'd0, 1'b1, 1'b0, "R6 gone after invalidate");
    do_cmd(4'd0, 1'b0, 1'b0, 1'b1, 4'd5, 20'h00011, 64'h11);
    // R10 miss on write-back
    exp_st(1'b0, 64'h12, 16'd0, 1'b1, 1'b0, "R10 write-back miss");
    do_cmd(4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00055, 64'h12);
    idle();

    // R8 sweep: valid+dirty lines 0, 7, 9; line 5 invalid but dirty
    fill(1'b0, 4'd7, 20'h00077, DF, 1'b1, 16'd1);
    fill(1'b0, 4'd9, 20'h00099, DG, 1'b1, 16'd2);
    exp_wb(1'b0, 20'h00011, DA, "R8 sweep line 0");
    exp_wb(1'b0, 20'h00077, DF, "R8 sweep line 7");
    exp_wb(1'b0, 20'h00099, DG, "R8 sweep line 9");
    exp_st(1'b1, 64'h13, 16'd0, 1'b0, 1'b0, "R8 sweep status");
    do_cmd(4'd3, 1'b0, 1'b1, 1'b0, 4'd0, 20'h0, 64'h13);
    begin
      int n = 0;
      while (!cmd_ready) begin
        n++;
        @(negedge clk);
      end
      chk("R8 busy cycles", 64'(n), 64'(LINES));
    end
    exp_st(1'b0, 64'h14, 16'd0, 1'b0, 1'b0, "R8 clean sweep");
    do_cmd(4'd3, 1'b0, 1'b0, 1'b0, 4'd0, 20'h0, 64'h14);
    idle();
    fill(1'b0, 4'd4, 20'h00044, DH, 1'b1, 16'd6);
    exp_wb(1'b0, 20'h00044, DH, "R8 wbinv sweep");
    exp_st(1'b0, 64'h15, 16'd0, 1'b0, 1'b0, "R8 wbinv sweep status");
    do_cmd(4'd7, 1'b0, 1'b0, 1'b0, 4'd0, 20'h0, 64'h15);
    exp_st(1'b0, 64'h16, 16'd0, 1'b1, 1'b0, "R8 all invalid");
    do_cmd(4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 20'h00022, 64'h16);
    idle();
    fill(1'b1, 4'd2, 20'h00066, DI, 1'b1, 16'd8);
    exp_st(1'b0, 64'h17, 16'd0, 1'b0, 1'b0, "R8 invalidate sweep");
    do_cmd(4'd5, 1'b1, 1'b0, 1'b0, 4'd0, 20'h0, 64'h17);
    exp_st(1'b0, 64'h18, 16'd0, 1'b1, 1'b0, "R8 invalidated without write-back");
    do_cmd(4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 20'h00066, 64'h18);

    idle();
    repeat (4) @(negedge clk);
    chk("R2 statuses outstanding", 64'(st_q.size()), 64'd0);
    chk("R8 write-backs outstanding", 64'(wb_q.size()), 64'd0);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule